// File: doc/BRIEF.md
# Packed Signed Saturating Vector Adder/Subtractor

This block takes two 128-bit vectors of packed signed integers and returns their element-wise sum or difference, clamped to the representable range rather than wrapping. A mode pin treats the vectors as four 32-bit lanes or as two 64-bit lanes. Each lane first produces its ordinary two's-complement (wrapping) result. A three-input truth table indexed by the sign bits of operand A, operand B and the wrapped result then decides whether that lane went out of range. A flagged lane is replaced by its clamp value. That value is made by copying the wrapped result's sign bit into every bit of the lane and then inverting the lane's top bit.

Operations enter through a valid/ready input stream and leave through a valid/ready output stream with a single register stage. The input is accepted whenever the output register is empty or is being emptied in the same cycle. While the consumer holds `out_ready` low with `out_valid` high, the output holds still and the input stalls. The operation select and lane-width select travel with the input beat.

Top module: `sat_vec_addsub`

## Requirements
- R1: With `in_sub`=0, each lane whose true sum fits in the lane's signed range outputs the two's-complement sum of its A and B elements.
- R2: With `in_sub`=1, each lane whose true difference A−B fits in range outputs that difference.
- R3: For addition, a lane saturates exactly when the table 8'h42 has a 1 at bit index {signA, signB, signResult}, where signResult is the wrapped sum's top bit. This is the case where both inputs share a sign and the wrapped sum's sign differs from A.
- R4: For subtraction, a lane saturates exactly when the table 8'h18 has a 1 at bit index {signA, signB, signResult}. This is the case where the inputs differ in sign and the wrapped difference's sign differs from A.
- R5: A saturated lane outputs 0x7FF…F when its wrapped result's top bit is 1 (overflow upward), and 0x800…0 when that bit is 0 (overflow downward).
- R6: With `in_wide`=0, no carry or borrow crosses a 32-bit boundary. With `in_wide`=1, carries cross the boundary at bit 32 and at bit 96, but not the one at bit 64. Lane k occupies bits [32k+31:32k] or [64k+63:64k].
- R7: With `in_wide`=0, `out_flags[k]` is 1 when 32-bit lane k saturated. With `in_wide`=1, `out_flags[k]` for k in 0..1 marks 64-bit lane k, and `out_flags[3:2]` are 0.
- R8: `in_ready` is high when `out_valid` is low or `out_ready` is high. An input accepted on a clock edge appears on `out_data`/`out_flags` with `out_valid` high right after that edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_flags` keep their values.
- R10: After reset, `out_valid`, `out_data` and `out_flags` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_a | input | 128 | Operand A vector |
| in_b | input | 128 | Operand B vector |
| in_sub | input | 1 | 1 = A−B, 0 = A+B |
| in_wide | input | 1 | 1 = two 64-bit lanes, 0 = four 32-bit lanes |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Saturated result vector |
| out_flags | output | 4 | Per-lane saturation flags |

## Verification
Every result and its flags are due one edge after the edge that accepts the input. The bench drives each beat at a falling edge and inspects the outputs at the next falling edge, halfway between the accepting edge and the one after it. In the back-pressure test the result is read again at several later falling edges while `out_ready` is low. The stalled second beat is expected at the first falling edge after `out_ready` returns high. Expected lane values come from widened signed arithmetic compared against the lane's range, not from the sign table.

// File: rtl/sat_pkg.sv
package sat_pkg;
  // Sign-bit tables, indexed by {signA, signB, signResult}
  localparam logic [7:0] DET_TBL_ADD = 8'h42;
  localparam logic [7:0] DET_TBL_SUB = 8'h18;

  function automatic logic det_pick(input logic [7:0] tbl, input logic sa,
                                    input logic sb, input logic sr);
    return tbl[{sa, sb, sr}];
  endfunction
endpackage

// File: rtl/sat_seg_adder.sv
module sat_seg_adder #(
  parameter int VEC_W = 128,
  parameter int SEG_W = 32,
  parameter int SEG_PER_WIDE = 2
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic             sub,
  input  logic             wide,
  output logic [VEC_W-1:0] sum
);
  localparam int SEG_N = VEC_W / SEG_W;

  logic [VEC_W-1:0] b_eff;
  logic [SEG_N-1:0] cout;
  logic [SEG_N-1:0] cin;

  assign b_eff = sub ? ~b : b;

  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    if ((i % SEG_PER_WIDE) != 0) begin : g_inner
      // chain only inside a wide lane
      assign cin[i] = wide ? cout[i-1] : sub;
    end else begin : g_first
      assign cin[i] = sub;
    end
    logic [SEG_W:0] part;
    assign part = {1'b0, a[i*SEG_W +: SEG_W]} + {1'b0, b_eff[i*SEG_W +: SEG_W]}
                  + {{SEG_W{1'b0}}, cin[i]};
    assign sum[i*SEG_W +: SEG_W] = part[SEG_W-1:0];
    assign cout[i] = part[SEG_W];
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
  import sat_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int SEG_W = 32,
  parameter int SEG_PER_WIDE = 2
) (
  input  logic [VEC_W-1:0]         a,
  input  logic [VEC_W-1:0]         b,
  input  logic [VEC_W-1:0]         sum,
  input  logic                     sub,
  input  logic                     wide,
  output logic [VEC_W-1:0]         res,
  output logic [VEC_W/SEG_W-1:0]   flags
);
  localparam int SEG_N = VEC_W / SEG_W;
  localparam int WIDE_N = SEG_N / SEG_PER_WIDE;

  logic [7:0]       tbl;
  logic [SEG_N-1:0] det;

  assign tbl = sub ? DET_TBL_SUB : DET_TBL_ADD;

  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    localparam int TOP = i*SEG_W + SEG_W - 1;
    localparam int LT  = (i / SEG_PER_WIDE) * SEG_PER_WIDE + SEG_PER_WIDE - 1;
    localparam int LTOP = LT*SEG_W + SEG_W - 1;
    localparam bit IS_HIGH = (i % SEG_PER_WIDE) == (SEG_PER_WIDE - 1);

    logic lane_sat, lane_sign, top_here;
    logic [SEG_W-1:0] clampv;

    assign det[i]    = det_pick(tbl, a[TOP], b[TOP], sum[TOP]);
    assign lane_sat  = wide ? det[LT] : det[i];
    assign lane_sign = wide ? sum[LTOP] : sum[TOP];
    assign top_here  = wide ? IS_HIGH : 1'b1;
    // spread sign, then flip the lane's top bit
    assign clampv = {SEG_W{lane_sign}} ^ {top_here, {(SEG_W-1){1'b0}}};
    assign res[i*SEG_W +: SEG_W] = lane_sat ? clampv : sum[i*SEG_W +: SEG_W];

    if (i < WIDE_N) begin : g_flag_lo
      assign flags[i] = wide ? det[i*SEG_PER_WIDE + SEG_PER_WIDE - 1] : det[i];
    end else begin : g_flag_hi
      assign flags[i] = wide ? 1'b0 : det[i];
    end
  end
endmodule

// File: rtl/sat_vec_addsub.sv
module sat_vec_addsub #(
  parameter int VEC_W = 128,
  parameter int SEG_W = 32,
  parameter int SEG_PER_WIDE = 2,
  localparam int SEG_N = VEC_W / SEG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_a,
  input  logic [VEC_W-1:0] in_b,
  input  logic             in_sub,
  input  logic             in_wide,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data,
  output logic [SEG_N-1:0] out_flags
);
  localparam int WIDE_N = SEG_N / SEG_PER_WIDE;

  logic [VEC_W-1:0] wrap_sum;
  logic [VEC_W-1:0] sat_res;
  logic [SEG_N-1:0] sat_flags;
  logic             accept;
  logic             wide_q;

  sat_seg_adder #(.VEC_W(VEC_W), .SEG_W(SEG_W), .SEG_PER_WIDE(SEG_PER_WIDE)) u_add (
    .a(in_a), .b(in_b), .sub(in_sub), .wide(in_wide), .sum(wrap_sum)
  );

  sat_clamp #(.VEC_W(VEC_W), .SEG_W(SEG_W), .SEG_PER_WIDE(SEG_PER_WIDE)) u_clamp (
    .a(in_a), .b(in_b), .sum(wrap_sum), .sub(in_sub), .wide(in_wide),
    .res(sat_res), .flags(sat_flags)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flags <= '0;
      wide_q    <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= sat_res;
      out_flags <= sat_flags;
      wide_q    <= in_wide;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R8

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_flags))); // R9

  AST_WIDE_UPPER_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wide_q) |-> (out_flags[SEG_N-1:WIDE_N] == '0)); // R7

  AST_CLAMP_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_q && out_flags[0]) |->
      (out_data[SEG_W-1:0] == {1'b0, {(SEG_W-1){1'b1}}} ||
       out_data[SEG_W-1:0] == {1'b1, {(SEG_W-1){1'b0}}})); // R5
endmodule

// File: tb/sat_vec_addsub_tb.sv
module sat_vec_addsub_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_a = '0, in_b = '0;
  logic         in_sub = 1'b0, in_wide = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic [3:0]   out_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sat_vec_addsub u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sub(in_sub), .in_wide(in_wide),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_flags(out_flags)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected lane by widened signed arithmetic and range compare
  task automatic lane_model(input logic [63:0] a, input logic [63:0] b, input bit sub,
                            input bit w64, output logic [63:0] r, output bit f);
    logic signed [65:0] ea, eb, t, mx, mn;
    if (w64) begin
      ea = {{2{a[63]}}, a}; eb = {{2{b[63]}}, b};
      mx = 66'sh0_7FFF_FFFF_FFFF_FFFF; mn = -66'sh0_8000_0000_0000_0000;
    end else begin
      ea = {{34{a[31]}}, a[31:0]}; eb = {{34{b[31]}}, b[31:0]};
      mx = 66'sh7FFF_FFFF; mn = -66'sh8000_0000;
    end
    t = sub ? ea - eb : ea + eb;
    f = 1'b0;
    if (t > mx) begin t = mx; f = 1'b1; end
    if (t < mn) begin t = mn; f = 1'b1; end
    r = t[63:0];
  endtask

  task automatic vec_model(input logic [127:0] a, input logic [127:0] b, input bit sub,
                           input bit w64, output logic [127:0] r, output logic [3:0] f);
    logic [63:0] lr; bit lf;
    r = '0; f = '0;
    if (w64) begin
      for (int k = 0; k < 2; k++) begin
        lane_model(a[64*k +: 64], b[64*k +: 64], sub, 1'b1, lr, lf);
        r[64*k +: 64] = lr; f[k] = lf;
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        lane_model({32'd0, a[32*k +: 32]}, {32'd0, b[32*k +: 32]}, sub, 1'b0, lr, lf);
        r[32*k +: 32] = lr[31:0]; f[k] = lf;
      end
    end
  endtask

  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input bit sub,
                        input bit w64, input string req);
    logic [127:0] er; logic [3:0] ef;
    vec_model(a, b, sub, w64, er, ef);
    @(negedge clk);
    in_a = a; in_b = b; in_sub = sub; in_wide = w64; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R8", {127'd0, out_valid}, 128'd1);
    chk(out_data == er, req, out_data, er);
    chk(out_flags == ef, "R7", {124'd0, out_flags}, {124'd0, ef});
  endtask

  function automatic logic [31:0] c32(input int i);
    case (i % 8)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;  3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;  5: return 32'h7FFF_FFFE;
      6: return 32'h8000_0001;  default: return 32'h4000_0000;
    endcase
  endfunction

  function automatic logic [63:0] c64(input int i);
    case (i % 8)
      0: return 64'h0;                    1: return 64'h1;
      2: return 64'hFFFF_FFFF_FFFF_FFFF;  3: return 64'h7FFF_FFFF_FFFF_FFFF;
      4: return 64'h8000_0000_0000_0000;  5: return 64'h0000_0000_FFFF_FFFF;
      6: return 64'h8000_0000_0000_0001;  default: return 64'h4000_0000_0000_0000;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, er1, er2;
    logic [3:0] ef;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10", {126'd0, out_valid, in_ready}, 128'd1);
    chk(out_data == '0 && out_flags == '0, "R10", out_data, 128'd0);
    rst_n = 1'b1;

    // Narrow-lane sweep over corner pairs: R1 R2 R3 R4 R5
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          for (int k = 0; k < 4; k++) begin
            a[32*k +: 32] = c32(i + k);
            b[32*k +: 32] = c32(j + 3*k);
          end
          run_op(a, b, s[0], 1'b0, s ? "R2 R4 R5" : "R1 R3 R5");
        end

    // Wide-lane sweep: R1 R2 R3 R4 R5
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          a = {c64(i + 1), c64(i)};
          b = {c64(j + 5), c64(j)};
          run_op(a, b, s[0], 1'b1, s ? "R2 R4 R5" : "R1 R3 R5");
        end

    // R6 carry isolation
    run_op({32'd5, 32'd0, 32'd7, 32'hFFFF_FFFF}, {32'd0, 32'd0, 32'd0, 32'd1}, 1'b0, 1'b0, "R6");
    run_op({64'd3, 64'h0000_0000_FFFF_FFFF}, {64'd0, 64'd1}, 1'b0, 1'b1, "R6");
    run_op({64'd0, 64'h0000_0001_0000_0000}, {64'd0, 64'd1}, 1'b1, 1'b1, "R6");
    run_op({64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h0, 64'd1}, 1'b0, 1'b1, "R6");

    // Pseudo-random mix
    for (int n = 0; n < 200; n++) begin
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      run_op(a, b, n[0], n[1], "R1 R2 R5");
    end

    // Back-pressure: R8 R9
    @(negedge clk);
    out_ready = 1'b0;
    vec_model({4{32'h7000_0000}}, {4{32'h2000_0000}}, 1'b0, 1'b0, er1, ef);
    in_a = {4{32'h7000_0000}}; in_b = {4{32'h2000_0000}}; in_sub = 1'b0; in_wide = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid && out_data == er1, "R8", out_data, er1);
    vec_model({2{64'd10}}, {2{64'd3}}, 1'b1, 1'b1, er2, ef);
    in_a = {2{64'd10}}; in_b = {2{64'd3}}; in_sub = 1'b1; in_wide = 1'b1;
    chk(in_ready == 1'b0, "R8", {127'd0, in_ready}, 128'd0);
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      chk(out_valid && out_data == er1 && out_flags == 4'hF, "R9", out_data, er1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data == er2 && out_flags == 4'h0, "R8", out_data, er2);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", {127'd0, out_valid}, 128'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule